// File: doc/BRIEF.md
# Lossy Block Rebuilder with Header Packer

This block sits on the decompression path of a memory controller that stores 128-byte blocks in compressed form. Once a block's symbols are decoded, an upstream stage hands over two things through separate valid/ready streams. The first is the block's header word. The second is the 64 decoded 16-bit symbols, in ascending position order. The block rebuilds the 1024-bit block from these. If the header marks the block as lossy, a run of symbol positions was dropped during compression. Each dropped slot still arrives as a placeholder symbol, and the block overwrites it with a predicted value. The prediction is the first surviving symbol of the block. Only the index of that symbol is derived, so no cycle is added to the decode path.

The header is 32 bits, written most significant bit first:
- bit 31 is the lossy flag (1 = lossy, 0 = lossless);
- bits 30:25 hold the first dropped position;
- bits 24:21 hold the run length, where 0 means 16;
- bits 20:0 hold three 7-bit entry offsets for the second, third and fourth lanes of a four-lane parallel decoder, second lane highest.

A block that was stored uncompressed carries no header. The upstream stage marks it with a raw flag that travels with the header beat. A small combinational packer on the compression side builds the same header word from its fields.

Back-pressure rules:
- A header is accepted only while no block is in progress or pending.
- Symbols are accepted only after their header.
- The finished block is held stable on the output until the consumer takes it. While it waits, neither input stream is accepted.

Top module: `lossy_block_rebuilder`

## Requirements
- R1: `pk_hdr` is {pk_lossy, pk_start, 4-bit length field, pk_ptrs}, with the lossy flag at bit 31, the start at bits 30:25, the length field at bits 24:21 and the pointers at bits 20:0.
- R2: A `pk_len` of 16 packs as length field 0. A `pk_len` from 1 to 15 packs as itself.
- R3: In lossless mode (bit 31 = 0), symbol i of the block appears unchanged at `out_block[16*i+15:16*i]`.
- R4: In lossy mode with a start above 0, positions start through start+length-1 carry the value of symbol 0. All other positions carry their own symbols.
- R5: In lossy mode with a start of 0, positions 0 through length-1 carry the value of symbol `length`. All other positions carry their own symbols.
- R6: A length field of 0 in a received header means a run of 16 symbols.
- R7: A run that would reach past position 63 stops at position 63, and no position below the start is changed.
- R8: When `hdr_raw` is 1 at header acceptance, the header bits are ignored. The block is rebuilt with no substitution, and `way_ptrs` reads 0.
- R9: `out_valid` rises in the cycle after the 64th symbol is accepted, and not earlier.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_block` holds its value and both `sym_ready` and `hdr_ready` are 0. A symbol offered in that time has no effect on the block.
- R11: From the cycle after a header is accepted until its block is delivered, `way_ptrs` shows bits 20:0 of that header.
- R12: During and right after reset, `out_valid` and `sym_ready` are 0 and `hdr_ready` is 1. After a block is taken, `out_valid` drops and `hdr_ready` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pk_lossy | input | 1 | Packer: lossy flag |
| pk_start | input | 6 | Packer: first dropped position |
| pk_len | input | 5 | Packer: run length, 1 to 16 |
| pk_ptrs | input | 21 | Packer: three lane entry offsets |
| pk_hdr | output | 32 | Packer: header word |
| hdr_valid | input | 1 | Header beat offered |
| hdr_ready | output | 1 | Header beat can be accepted |
| hdr_raw | input | 1 | Block was stored uncompressed; header bits ignored |
| hdr_bits | input | 32 | Header word |
| sym_valid | input | 1 | Decoded symbol offered |
| sym_ready | output | 1 | Symbol can be accepted |
| sym_data | input | 16 | Decoded symbol, positions arrive 0 to 63 |
| way_ptrs | output | 21 | Lane entry offsets of the current header |
| out_valid | output | 1 | Rebuilt block available |
| out_ready | input | 1 | Consumer takes the block |
| out_block | output | 1024 | Rebuilt block, symbol i at bits 16*i+15:16*i |

## Verification
A wrong position counter or state register moves the whole block. It shows up as `out_valid` rising one or more cycles too early or too late, against a cycle-exact expectation. It also shows up as symbols sitting in neighbouring slots of `out_block`. A wrong prediction index or a stale "prediction seen" flag only affects the dropped run. It shows at delivery as a run filled with the wrong neighbour or with the placeholder values. The stimulus therefore places runs at the start of the block, in the middle, and across its end. Lost back-pressure shows within one cycle as a changed `out_block` or as a raised ready signal during a stall.

// File: rtl/lbr_pkg.sv
package lbr_pkg;
  localparam int DEF_SYM_W = 16;
  localparam int DEF_NSYM  = 64;
  localparam int DEF_CNT_W = 4;
  localparam int DEF_PTR_W = 7;
  localparam int DEF_NWAY  = 4;

  typedef enum logic [1:0] {
    ST_HDR = 2'd0,
    ST_SYM = 2'd1,
    ST_OUT = 2'd2
  } rb_state_e;
endpackage

// File: rtl/lbr_hdr_pack.sv
module lbr_hdr_pack #(
  parameter int NSYM  = lbr_pkg::DEF_NSYM,
  parameter int CNT_W = lbr_pkg::DEF_CNT_W,
  parameter int PTR_W = lbr_pkg::DEF_PTR_W,
  parameter int NWAY  = lbr_pkg::DEF_NWAY,
  localparam int IDX_W  = $clog2(NSYM),
  localparam int LEN_W  = CNT_W + 1,
  localparam int PTRS_W = (NWAY - 1) * PTR_W,
  localparam int HDR_W  = 1 + IDX_W + CNT_W + PTRS_W
) (
  input  logic              lossy,
  input  logic [IDX_W-1:0]  start,
  input  logic [LEN_W-1:0]  len,
  input  logic [PTRS_W-1:0] ptrs,
  output logic [HDR_W-1:0]  hdr
);
  localparam logic [LEN_W-1:0] FULL_RUN = LEN_W'(1 << CNT_W);

  logic [CNT_W-1:0] len_fld;

  // A full run folds onto the zero code of the length field.
  always_comb begin
    if (len == FULL_RUN) len_fld = '0;
    else                 len_fld = len[CNT_W-1:0];
  end

  assign hdr = {lossy, start, len_fld, ptrs};
endmodule

// File: rtl/lbr_hdr_unpack.sv
module lbr_hdr_unpack #(
  parameter int NSYM  = lbr_pkg::DEF_NSYM,
  parameter int CNT_W = lbr_pkg::DEF_CNT_W,
  parameter int PTR_W = lbr_pkg::DEF_PTR_W,
  parameter int NWAY  = lbr_pkg::DEF_NWAY,
  localparam int IDX_W  = $clog2(NSYM),
  localparam int POS_W  = IDX_W + 1,
  localparam int LEN_W  = CNT_W + 1,
  localparam int PTRS_W = (NWAY - 1) * PTR_W,
  localparam int HDR_W  = 1 + IDX_W + CNT_W + PTRS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              raw,
  input  logic [HDR_W-1:0]  bits,
  output logic              subst_en,
  output logic [IDX_W-1:0]  rng_lo,
  output logic [POS_W-1:0]  rng_hi,
  output logic [POS_W-1:0]  pred_idx,
  output logic [PTRS_W-1:0] way_ptrs
);
  localparam int LOSSY_B = HDR_W - 1;
  localparam int START_B = HDR_W - 2;
  localparam int CNT_B   = HDR_W - 2 - IDX_W;

  logic [IDX_W-1:0] f_start;
  logic [CNT_W-1:0] f_cnt;
  logic [LEN_W-1:0] run_len;
  logic [POS_W-1:0] hi_d;
  logic [POS_W-1:0] pidx_d;

  assign f_start = bits[START_B -: IDX_W];
  assign f_cnt   = bits[CNT_B -: CNT_W];

  // Zero in the length field stands for the longest run.
  always_comb begin
    if (f_cnt == '0) run_len = LEN_W'(1 << CNT_W);
    else             run_len = {1'b0, f_cnt};
    hi_d = POS_W'(f_start) + POS_W'(run_len) - POS_W'(1);
    // The prediction source is the first surviving symbol.
    if (f_start != '0) pidx_d = '0;
    else               pidx_d = POS_W'(run_len);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      subst_en <= 1'b0;
      rng_lo   <= '0;
      rng_hi   <= '0;
      pred_idx <= '0;
      way_ptrs <= '0;
    end else if (take) begin
      if (raw) begin
        subst_en <= 1'b0;
        rng_lo   <= '0;
        rng_hi   <= '0;
        pred_idx <= '0;
        way_ptrs <= '0;
      end else begin
        subst_en <= bits[LOSSY_B];
        rng_lo   <= f_start;
        rng_hi   <= hi_d;
        pred_idx <= pidx_d;
        way_ptrs <= bits[PTRS_W-1:0];
      end
    end
  end

  // R6
  run_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    subst_en |-> (rng_hi >= POS_W'(rng_lo)) && ((rng_hi - POS_W'(rng_lo)) < POS_W'(1 << CNT_W)));

  // R8
  raw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && raw |=> !subst_en && (way_ptrs == '0));
endmodule

// File: rtl/lbr_sym_store.sv
module lbr_sym_store #(
  parameter int SYM_W = lbr_pkg::DEF_SYM_W,
  parameter int NSYM  = lbr_pkg::DEF_NSYM,
  localparam int IDX_W = $clog2(NSYM),
  localparam int POS_W = IDX_W + 1,
  localparam int BLK_W = SYM_W * NSYM
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hdr_valid,
  output logic             hdr_ready,
  output logic             hdr_take,
  input  logic             subst_en,
  input  logic [IDX_W-1:0] rng_lo,
  input  logic [POS_W-1:0] rng_hi,
  input  logic [POS_W-1:0] pred_idx,
  input  logic             sym_valid,
  output logic             sym_ready,
  input  logic [SYM_W-1:0] sym_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [BLK_W-1:0] out_block
);
  import lbr_pkg::*;

  rb_state_e        state_q, state_d;
  logic [IDX_W-1:0] idx_q;
  logic [SYM_W-1:0] pred_q;
  logic             pred_seen_q;
  logic             fire;
  logic             last;
  logic             pred_now;

  assign hdr_ready = (state_q == ST_HDR);
  assign sym_ready = (state_q == ST_SYM);
  assign out_valid = (state_q == ST_OUT);
  assign hdr_take  = hdr_valid && hdr_ready;
  assign fire      = sym_valid && sym_ready;
  assign last      = (idx_q == IDX_W'(NSYM - 1));
  assign pred_now  = fire && subst_en && ({1'b0, idx_q} == pred_idx);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_HDR:  if (hdr_take)    state_d = ST_SYM;
      ST_SYM:  if (fire && last) state_d = ST_OUT;
      ST_OUT:  if (out_ready)   state_d = ST_HDR;
      default:                  state_d = ST_HDR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_HDR;
      idx_q       <= '0;
      pred_q      <= '0;
      pred_seen_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (hdr_take) begin
        idx_q       <= '0;
        pred_seen_q <= 1'b0;
      end else if (fire) begin
        idx_q <= idx_q + IDX_W'(1);
      end
      if (pred_now) begin
        pred_q      <= sym_data;
        pred_seen_q <= 1'b1;
      end
    end
  end

  // One storage slot per symbol position. A slot in the dropped run takes
  // the prediction as soon as it is known: either when the slot itself
  // arrives after the source, or by back-fill when the source arrives last.
  for (genvar i = 0; i < NSYM; i++) begin : g_slot
    logic [SYM_W-1:0] ent_q;
    logic             in_rng;

    assign in_rng = (POS_W'(i) >= POS_W'(rng_lo)) && (POS_W'(i) <= rng_hi);

    always_ff @(posedge clk) begin
      if (pred_now && in_rng) begin
        ent_q <= sym_data;
      end else if (fire && (idx_q == IDX_W'(i))) begin
        if (subst_en && in_rng && pred_seen_q) ent_q <= pred_q;
        else                                   ent_q <= sym_data;
      end
    end

    assign out_block[i*SYM_W +: SYM_W] = ent_q;
  end

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_block));

  // R9
  out_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(fire && last));

  // R9
  out_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && last |=> out_valid);

  // R5
  pred_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) && subst_en |-> pred_seen_q);
endmodule

// File: rtl/lossy_block_rebuilder.sv
module lossy_block_rebuilder #(
  parameter int SYM_W = lbr_pkg::DEF_SYM_W,
  parameter int NSYM  = lbr_pkg::DEF_NSYM,
  parameter int CNT_W = lbr_pkg::DEF_CNT_W,
  parameter int PTR_W = lbr_pkg::DEF_PTR_W,
  parameter int NWAY  = lbr_pkg::DEF_NWAY,
  localparam int IDX_W  = $clog2(NSYM),
  localparam int POS_W  = IDX_W + 1,
  localparam int LEN_W  = CNT_W + 1,
  localparam int PTRS_W = (NWAY - 1) * PTR_W,
  localparam int HDR_W  = 1 + IDX_W + CNT_W + PTRS_W,
  localparam int BLK_W  = SYM_W * NSYM
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pk_lossy,
  input  logic [IDX_W-1:0]  pk_start,
  input  logic [LEN_W-1:0]  pk_len,
  input  logic [PTRS_W-1:0] pk_ptrs,
  output logic [HDR_W-1:0]  pk_hdr,
  input  logic              hdr_valid,
  output logic              hdr_ready,
  input  logic              hdr_raw,
  input  logic [HDR_W-1:0]  hdr_bits,
  input  logic              sym_valid,
  output logic              sym_ready,
  input  logic [SYM_W-1:0]  sym_data,
  output logic [PTRS_W-1:0] way_ptrs,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BLK_W-1:0]  out_block
);
  logic             hdr_take;
  logic             subst_en;
  logic [IDX_W-1:0] rng_lo;
  logic [POS_W-1:0] rng_hi;
  logic [POS_W-1:0] pred_idx;

  lbr_hdr_pack #(
    .NSYM(NSYM), .CNT_W(CNT_W), .PTR_W(PTR_W), .NWAY(NWAY)
  ) u_pack (
    .lossy (pk_lossy),
    .start (pk_start),
    .len   (pk_len),
    .ptrs  (pk_ptrs),
    .hdr   (pk_hdr)
  );

  lbr_hdr_unpack #(
    .NSYM(NSYM), .CNT_W(CNT_W), .PTR_W(PTR_W), .NWAY(NWAY)
  ) u_unpack (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (hdr_take),
    .raw      (hdr_raw),
    .bits     (hdr_bits),
    .subst_en (subst_en),
    .rng_lo   (rng_lo),
    .rng_hi   (rng_hi),
    .pred_idx (pred_idx),
    .way_ptrs (way_ptrs)
  );

  lbr_sym_store #(
    .SYM_W(SYM_W), .NSYM(NSYM)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .hdr_valid (hdr_valid),
    .hdr_ready (hdr_ready),
    .hdr_take  (hdr_take),
    .subst_en  (subst_en),
    .rng_lo    (rng_lo),
    .rng_hi    (rng_hi),
    .pred_idx  (pred_idx),
    .sym_valid (sym_valid),
    .sym_ready (sym_ready),
    .sym_data  (sym_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_block (out_block)
  );
endmodule

// File: tb/lossy_block_rebuilder_tb.sv
module lossy_block_rebuilder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;
  localparam int NVEC       = 8;

  typedef struct packed {
    logic       raw;
    logic       lossy;
    logic [5:0] start;
    logic [4:0] len;
    logic [7:0] seed;
    logic       hold;
  } vec_t;

  // raw, lossy, start, len, seed, hold
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 6'd5,  5'd3,  8'd1, 1'b0},
    '{1'b0, 1'b1, 6'd10, 5'd4,  8'd2, 1'b1},
    '{1'b0, 1'b1, 6'd0,  5'd5,  8'd3, 1'b0},
    '{1'b0, 1'b1, 6'd0,  5'd16, 8'd4, 1'b0},
    '{1'b0, 1'b1, 6'd60, 5'd16, 8'd5, 1'b1},
    '{1'b1, 1'b1, 6'd3,  5'd7,  8'd6, 1'b0},
    '{1'b0, 1'b1, 6'd63, 5'd1,  8'd7, 1'b0},
    '{1'b0, 1'b1, 6'd1,  5'd16, 8'd8, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pk_lossy = 1'b0;
  logic [5:0]    pk_start = '0;
  logic [4:0]    pk_len = 5'd1;
  logic [20:0]   pk_ptrs = '0;
  logic [31:0]   pk_hdr;
  logic          hdr_valid = 1'b0;
  logic          hdr_ready;
  logic          hdr_raw = 1'b0;
  logic [31:0]   hdr_bits = '0;
  logic          sym_valid = 1'b0;
  logic          sym_ready;
  logic [15:0]   sym_data = '0;
  logic [20:0]   way_ptrs;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [1023:0] out_block;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lossy_block_rebuilder dut_i (
    .clk(clk), .rst_n(rst_n),
    .pk_lossy(pk_lossy), .pk_start(pk_start), .pk_len(pk_len),
    .pk_ptrs(pk_ptrs), .pk_hdr(pk_hdr),
    .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_raw(hdr_raw),
    .hdr_bits(hdr_bits),
    .sym_valid(sym_valid), .sym_ready(sym_ready), .sym_data(sym_data),
    .way_ptrs(way_ptrs),
    .out_valid(out_valid), .out_ready(out_ready), .out_block(out_block)
  );

  function automatic logic [15:0] gen_sym(logic [7:0] seed, int i);
    return 16'(int'(seed) * 16'h0905 + i * 16'h0123 + i * i + 1);
  endfunction

  function automatic logic [20:0] gen_ptrs(logic [7:0] seed);
    return {7'(seed), 7'(seed + 8'd3), 7'(seed + 8'd5)};
  endfunction

  function automatic logic [31:0] mk_hdr(vec_t v);
    logic [3:0] fld;
    fld = (v.len == 5'd16) ? 4'd0 : v.len[3:0];
    return {v.lossy, v.start, fld, gen_ptrs(v.seed)};
  endfunction

  function automatic logic [1023:0] expect_blk(vec_t v);
    logic [1023:0] b;
    logic [15:0]   pred;
    int            lo;
    int            hi;
    lo   = int'(v.start);
    hi   = lo + int'(v.len) - 1;
    pred = (lo > 0) ? gen_sym(v.seed, 0) : gen_sym(v.seed, int'(v.len));
    for (int i = 0; i < 64; i++) begin
      if (!v.raw && v.lossy && i >= lo && i <= hi) b[i*16 +: 16] = pred;
      else                                         b[i*16 +: 16] = gen_sym(v.seed, i);
    end
    return b;
  endfunction

  function automatic string blk_tag(vec_t v);
    if (v.raw)                                 return "R8";
    if (!v.lossy)                              return "R3";
    if (int'(v.start) + int'(v.len) > 64)      return "R7";
    if (v.start == 6'd0)                       return (v.len == 5'd16) ? "R5/R6" : "R5";
    if (v.len == 5'd16)                        return "R4/R6";
    return "R4";
  endfunction

  task automatic chk(bit ok, string req, logic [1023:0] act, logic [1023:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic run_block(vec_t v);
    logic [1023:0] exp_b;
    logic [1023:0] snap;
    exp_b = expect_blk(v);
    @(negedge clk);
    pk_lossy  = v.lossy;
    pk_start  = v.start;
    pk_len    = v.len;
    pk_ptrs   = gen_ptrs(v.seed);
    hdr_bits  = mk_hdr(v);
    hdr_raw   = v.raw;
    hdr_valid = 1'b1;
    #1;
    // R1 R2: packer layout and full-run code
    chk(pk_hdr == mk_hdr(v), "R1", 1024'(pk_hdr), 1024'(mk_hdr(v)));
    while (!hdr_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    hdr_valid = 1'b0;
    // R11: pointers shown after header acceptance
    chk(way_ptrs == (v.raw ? 21'd0 : gen_ptrs(v.seed)), v.raw ? "R8" : "R11",
        1024'(way_ptrs), 1024'(v.raw ? 21'd0 : gen_ptrs(v.seed)));
    for (int i = 0; i < 64; i++) begin
      sym_valid = 1'b1;
      sym_data  = gen_sym(v.seed, i);
      while (!sym_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      if (i == 62) chk(out_valid == 1'b0, "R9", 1024'(out_valid), 1024'(0));
    end
    sym_valid = 1'b0;
    // R9: valid the cycle after the last symbol
    chk(out_valid == 1'b1, "R9", 1024'(out_valid), 1024'(1));
    chk(out_block == exp_b, blk_tag(v), out_block, exp_b);
    chk(way_ptrs == (v.raw ? 21'd0 : gen_ptrs(v.seed)), "R11",
        1024'(way_ptrs), 1024'(v.raw ? 21'd0 : gen_ptrs(v.seed)));
    if (v.hold) begin
      snap = out_block;
      sym_valid = 1'b1;
      sym_data  = 16'hDEAD;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        // R10: stall holds block and blocks both inputs
        chk(out_valid && !sym_ready && !hdr_ready, "R10",
            1024'({out_valid, sym_ready, hdr_ready}), 1024'(3'b100));
        chk(out_block == snap, "R10", out_block, snap);
      end
      sym_valid = 1'b0;
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    // R12: block taken, back to idle
    chk(!out_valid && hdr_ready, "R12", 1024'({out_valid, hdr_ready}), 1024'(2'b01));
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12: reset state
    chk(!out_valid && !sym_ready && hdr_ready, "R12",
        1024'({out_valid, sym_ready, hdr_ready}), 1024'(3'b001));
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !sym_ready && hdr_ready, "R12",
        1024'({out_valid, sym_ready, hdr_ready}), 1024'(3'b001));

    // R10: a symbol offered before any header is not taken
    sym_valid = 1'b1;
    sym_data  = 16'hBEEF;
    @(negedge clk);
    chk(!sym_ready && !out_valid, "R10", 1024'({sym_ready, out_valid}), 1024'(0));
    sym_valid = 1'b0;

    // R2: explicit packer checks of the length field
    pk_len = 5'd16;
    #1;
    chk(pk_hdr[24:21] == 4'd0, "R2", 1024'(pk_hdr[24:21]), 1024'(0));
    pk_len = 5'd15;
    #1;
    chk(pk_hdr[24:21] == 4'd15, "R2", 1024'(pk_hdr[24:21]), 1024'(15));

    for (int n = 0; n < NVEC; n++) run_block(VECS[n]);

    done = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule